// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a slow time-base strobe (one clock-enable pulse per cycle of a 32.768 kHz reference) into a periodic interrupt. A small rate code chooses a power-of-two divisor of that reference. An enable input gates the whole function. When a period completes, two sticky status flags are raised and the interrupt request line goes high. The flags stay set until the surrounding register file sends a clear pulse. That pulse usually comes from a read of the status register.

The block keeps a free-running count of reference strobes from reset onward. It fires only when that count lands on a multiple of the selected period. As a result, the interrupt phase depends only on the time since reset, not on when software programmed the rate. Changing the rate code or the enable never restarts the count. The new setting applies from the next strobe.

Top module: `periodic_rate_gen`

## Requirements
- R1: After reset, both status flags and the interrupt request are 0, and the free-running strobe count is zero.
- R2: With rate code 0, no flag is ever set, whatever the enable and strobe inputs do.
- R3: With the enable input low, no flag is ever set, for any rate code.
- R4: For rate codes 3 through 15, the period is 2^(code-1) reference strobes; for example, code 3 fires every 4 strobes and code 15 every 16384.
- R5: Rate code 1 gives the same period as code 8 (128 strobes), and rate code 2 gives the same period as code 9 (256 strobes).
- R6: A period boundary is a strobe after which the number of strobes since reset, modulo 2^15, is a multiple of the period. The count keeps running across changes to the rate code and the enable, and a new setting applies from the next strobe.
- R7: A boundary sets both flags and the interrupt request on the clock edge that takes the strobe, so they are visible from the following cycle. All three outputs always carry the same value.
- R8: A clear pulse drops both flags and the interrupt request on the next edge. If a boundary falls in the same cycle as the clear, the flags are set instead.
- R9: Clock cycles without a strobe do not advance the count and do not change the flags unless a clear is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe at the 32.768 kHz reference rate |
| rate_i | input | CODE_W (4) | Rate code that selects the divisor |
| pie_en_i | input | 1 | Periodic interrupt enable |
| clr_i | input | 1 | Clears the flags (from the status read) |
| pf_o | output | 1 | Sticky periodic flag (status bit 6) |
| irqf_o | output | 1 | Sticky interrupt-pending flag (status bit 7) |
| irq_o | output | 1 | Interrupt request line |

## Verification
The bench builds the block with its default parameters: a 4-bit rate code and a 15-bit free-running count. This makes every code, including the longest period of 16384 strobes, reachable within the run. The bench resets the block before each code and holds the clear high, so each boundary shows as exactly one cycle of high output. The number of such cycles is compared with the number of multiples of the period that a given number of strobes should produce. The remapped low codes, code 0, a disabled generator and idle cycles without strobes each get their own directed runs. After those, random strobes, codes, enables and clears are compared cycle by cycle against a bench model of the aligned count. This exercises rate changes in the middle of a period.

// File: rtl/prg_pkg.sv
package prg_pkg;

   // Low codes at or below this value are moved up by REMAP_ADD.
   localparam int unsigned REMAP_MAX = 2;
   localparam int unsigned REMAP_ADD = 7;

   // Number of low count bits that must be zero at a boundary for a given code.
   function automatic int unsigned prg_shift(input int unsigned code);
      int unsigned eff;
      eff = code;
      if (code != 0 && code <= REMAP_MAX) eff = code + REMAP_ADD;
      if (eff == 0) return 0;
      return eff - 1;
   endfunction

   // Largest shift over all codes of a given width.
   function automatic int unsigned prg_max_shift(input int unsigned code_w);
      int unsigned m;
      m = 0;
      for (int unsigned c = 1; c < (1 << code_w); c++)
         if (prg_shift(c) > m) m = prg_shift(c);
      return m;
   endfunction

endpackage

// File: rtl/prg_free_counter.sv
module prg_free_counter #(
   parameter int unsigned CNT_W = 15
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cnt_next_o
);

   initial begin
      if (CNT_W < 2) $error("prg_free_counter: CNT_W must be at least 2");
   end

   assign cnt_next_o = cnt_o + CNT_W'(1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_o <= '0;
      else if (tick_i) cnt_o <= cnt_next_o;
   end

endmodule

// File: rtl/prg_boundary_detect.sv
module prg_boundary_detect
   import prg_pkg::*;
#(
   parameter int unsigned CODE_W = 4,
   parameter int unsigned CNT_W  = 15
) (
   input  logic [CNT_W-1:0]  cnt_next_i,
   input  logic [CODE_W-1:0] rate_i,
   input  logic              tick_i,
   input  logic              pie_en_i,
   output logic              boundary_o
);

   localparam int unsigned NCODES = 1 << CODE_W;

   initial begin
      if (CNT_W <= prg_max_shift(CODE_W))
         $error("prg_boundary_detect: CNT_W too narrow for the longest period");
   end

   logic [NCODES-1:0] hit;

   // One aligned-zero comparator per code, picked by the code below.
   for (genvar c = 0; c < NCODES; c++) begin : g_code
      localparam int unsigned SH = prg_shift(c);
      if (c == 0) begin : g_off
         assign hit[c] = 1'b0;
      end else if (SH == 0) begin : g_every
         assign hit[c] = 1'b1;
      end else begin : g_cmp
         assign hit[c] = (cnt_next_i[SH-1:0] == '0);
      end
   end

   assign boundary_o = tick_i & pie_en_i & hit[rate_i];

endmodule

// File: rtl/prg_flag_reg.sv
module prg_flag_reg #(
   parameter int unsigned N_FLAGS = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               set_i,
   input  logic               clr_i,
   output logic [N_FLAGS-1:0] flags_o
);

   initial begin
      if (N_FLAGS < 1) $error("prg_flag_reg: N_FLAGS must be positive");
   end

   // Set has priority so a boundary coinciding with a clear is not lost.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     flags_o <= '0;
      else if (set_i)  flags_o <= '1;
      else if (clr_i)  flags_o <= '0;
   end

endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen
   import prg_pkg::*;
#(
   parameter int unsigned CODE_W = 4,
   parameter int unsigned CNT_W  = 15
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic [CODE_W-1:0] rate_i,
   input  logic              pie_en_i,
   input  logic              clr_i,
   output logic              pf_o,
   output logic              irqf_o,
   output logic              irq_o
);

   localparam int unsigned N_FLAGS = 2;
   localparam int unsigned PF_BIT  = 0;
   localparam int unsigned IRQ_BIT = 1;

   initial begin
      if (CODE_W < 2 || CODE_W > 8) $error("periodic_rate_gen: CODE_W out of range");
   end

   logic [CNT_W-1:0]   free_cnt;
   logic [CNT_W-1:0]   free_cnt_next;
   logic               boundary;
   logic [N_FLAGS-1:0] flags;

   prg_free_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .cnt_o      (free_cnt),
      .cnt_next_o (free_cnt_next)
   );

   prg_boundary_detect #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_bnd (
      .cnt_next_i (free_cnt_next),
      .rate_i     (rate_i),
      .tick_i     (tick_i),
      .pie_en_i   (pie_en_i),
      .boundary_o (boundary)
   );

   prg_flag_reg #(.N_FLAGS(N_FLAGS)) u_flags (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (boundary),
      .clr_i   (clr_i),
      .flags_o (flags)
   );

   assign pf_o   = flags[PF_BIT];
   assign irqf_o = flags[IRQ_BIT];
   assign irq_o  = flags[IRQ_BIT];

endmodule

// File: rtl/prg_checker.sv
module prg_checker #(
   parameter int unsigned CODE_W = 4,
   parameter int unsigned CNT_W  = 15
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              tick_i,
   input logic [CODE_W-1:0] rate_i,
   input logic              pie_en_i,
   input logic              clr_i,
   input logic              pf_o,
   input logic              irqf_o,
   input logic              irq_o,
   input logic [CNT_W-1:0]  free_cnt
);

   AST_RESET_CLEAN: assert property (@(posedge clk_i) !rst_ni |=> (!irq_o && !pf_o && free_cnt == '0)); // R1

   AST_CODE_ZERO_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> $past(rate_i != '0)); // R2

   AST_ENABLE_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pf_o) |-> $past(pie_en_i)); // R3

   AST_RISE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irqf_o) |-> $past(tick_i)); // R7

   AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !tick_i) |=> (!irq_o && !pf_o)); // R8

   AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !clr_i) |=> ($stable(irq_o) && $stable(free_cnt))); // R9

   AST_COUNT_STEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i |=> (free_cnt == $past(free_cnt) + CNT_W'(1))); // R6

endmodule

bind periodic_rate_gen prg_checker #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .tick_i   (tick_i),
   .rate_i   (rate_i),
   .pie_en_i (pie_en_i),
   .clr_i    (clr_i),
   .pf_o     (pf_o),
   .irqf_o   (irqf_o),
   .irq_o    (irq_o),
   .free_cnt (free_cnt)
);

// File: tb/periodic_rate_gen_tb.sv
module periodic_rate_gen_tb;

   localparam int CLK_PERIOD = 10;
   localparam int CODE_W     = 4;
   localparam int CNT_W      = 15;
   localparam int WATCHDOG   = 190000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick = 1'b0;
   logic [CODE_W-1:0] rate = '0;
   logic              pie = 1'b0;
   logic              clr = 1'b0;
   logic              pf, irqf, irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   string cur_tag = "R1";

   // Bench model state.
   logic [CNT_W-1:0] m_cnt = '0;
   logic             m_flag = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   periodic_rate_gen #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rate_i(rate),
      .pie_en_i(pie), .clr_i(clr), .pf_o(pf), .irqf_o(irqf), .irq_o(irq)
   );

   function automatic int period_of(input int code);
      int eff;
      eff = (code == 1 || code == 2) ? code + 7 : code;
      return 1 << (eff - 1);
   endfunction

   function automatic bit is_boundary(input logic [CNT_W-1:0] cnt, input int code, input bit en);
      int nxt;
      if (code == 0 || !en) return 1'b0;
      nxt = (int'(cnt) + 1) % (1 << CNT_W);
      return (nxt % period_of(code)) == 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt  <= '0;
         m_flag <= 1'b0;
      end else begin
         if (tick && is_boundary(m_cnt, int'(rate), pie)) m_flag <= 1'b1;
         else if (clr) m_flag <= 1'b0;
         if (tick) m_cnt <= m_cnt + CNT_W'(1);
      end
   end

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   int high_cnt = 0;

   // One clock: edge, then compare against the model away from the edge.
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      check(cur_tag, "irq", int'(irq), int'(m_flag));
      check(cur_tag, "pf", int'(pf), int'(m_flag));
      check("R7", "irqf", int'(irqf), int'(m_flag));
      if (irq) high_cnt++;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick = 1'b0; clr = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      high_cnt = 0;
   endtask

   task automatic run_count(input string tag, input int code, input bit en, input int n, input int exp_events);
      do_reset();
      cur_tag = tag;
      rate = CODE_W'(code); pie = en; clr = 1'b1; tick = 1'b1;
      repeat (n) step();
      tick = 1'b0; clr = 1'b0;
      check(tag, $sformatf("events code %0d", code), high_cnt, exp_events);
   endtask

   initial begin
      void'($urandom(32'h0051_7A1E));
      do_reset();
      @(negedge clk);
      // R1: reset state
      check("R1", "pf after reset", int'(pf), 0);
      check("R1", "irq after reset", int'(irq), 0);

      // R4: codes 3..15, two periods each, clear held so each event is one high cycle
      for (int c = 3; c < 16; c++) run_count("R4", c, 1'b1, 2 * period_of(c), 2);
      // R5: remapped low codes
      run_count("R5", 1, 1'b1, 256, 2);
      run_count("R5", 2, 1'b1, 512, 2);
      // R2: code zero never fires
      run_count("R2", 0, 1'b1, 300, 0);
      // R3: enable low never fires
      run_count("R3", 3, 1'b0, 300, 0);

      // R9: idle cycles do not advance the count
      do_reset();
      cur_tag = "R9";
      rate = 4'd3; pie = 1'b1; clr = 1'b0; tick = 1'b0;
      repeat (40) step();
      check("R9", "no event without strobes", high_cnt, 0);
      tick = 1'b1;
      repeat (3) step();
      check("R9", "not yet at third strobe", int'(irq), 0);
      step();
      check("R9", "event at fourth strobe", int'(irq), 1);

      // R8: flag sticks without clear, drops on clear
      tick = 1'b0;
      cur_tag = "R8";
      repeat (5) step();
      check("R8", "flag sticky", int'(irq), 1);
      clr = 1'b1;
      step();
      check("R8", "clear drops", int'(irq), 0);
      // set wins over clear: next boundary at count 8 while clear held
      tick = 1'b1;
      repeat (4) step();
      check("R8", "set beats clear", int'(irq), 1);
      clr = 1'b0; tick = 1'b0;

      // R6: enabling late keeps alignment to the count since reset
      do_reset();
      cur_tag = "R6";
      rate = 4'd4; pie = 1'b0; tick = 1'b1;
      repeat (6) step();
      pie = 1'b1;
      step();
      check("R6", "no event at count 7", int'(irq), 0);
      step();
      check("R6", "aligned event at count 8", int'(irq), 1);
      rate = 4'd3; clr = 1'b1;
      repeat (4) step();
      check("R6", "rate change keeps phase, count 12", int'(irq), 1);

      // Random phase against the model
      cur_tag = "R6";
      for (int i = 0; i < 60000; i++) begin
         if (i % 4000 == 0) rate = CODE_W'($urandom_range(0, 15) % 8);
         tick = ($urandom_range(0, 3) != 0);
         pie  = ($urandom_range(0, 9) != 0);
         clr  = ($urandom_range(0, 15) == 0);
         step();
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule